// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit turns a logical address, given as a segment number and an offset, into a physical address. It uses a table of segment descriptors held in ordinary memory. Two configuration inputs set where that table starts and how many segments it holds. Each request starts a short sequence. The unit first checks the segment number against the table size. It then reads the descriptor through a read port that allows one outstanding read. Finally it checks the validity flag, the offset bound and the access permission, and reports one of two results: a physical address, or a fault code.

Requests arrive through a valid/ready handshake and are taken only while the unit is idle. The result comes back with a single-cycle done pulse. The fault code names the first check that failed, in a fixed order: table size, then validity, then offset bound, then permission.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `fault` is 0 and `mem_req_valid` is 0.
- R2: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from the cycle after acceptance until the cycle after the done pulse, and stays low on every cycle a memory read is pending.
- R3: If the segment number is greater than or equal to `cfg_tlen`, the unit reports fault code 1 (table size) on the cycle after acceptance and issues no memory read for that request.
- R4: For a segment number below `cfg_tlen`, the unit reads the descriptor at byte address `cfg_tbase + 8*seg`.
- R5: The descriptor layout is: bits 31:0 the segment base, bits 51:32 the segment limit, bit 52 the valid flag, bit 53 read allowed, bit 54 write allowed, bit 55 execute allowed. If the valid flag is 0, the fault code is 2 (invalid).
- R6: If the offset is greater than or equal to the limit field, the fault code is 3 (limit). An offset of limit-1 passes this check.
- R7: The access type is encoded as 0 read, 1 write, 2 execute and 3 reserved. A read needs bit 53, a write needs bit 54 and an execute needs bit 55. A reserved type always fails the permission check. A failure gives fault code 4 (permission).
- R8: When every check passes, `fault` is 0 and `phys_addr` equals the base plus the zero-extended offset.
- R9: When several checks would fail, only the first in the order table size, valid, limit, permission is reported.
- R10: `done` is high for exactly one cycle per request. `fault` is 0 whenever `done` is low, and `phys_addr` is 0 whenever `fault` is nonzero.
- R11: Once `mem_req_valid` is raised, it stays high with `mem_req_addr` unchanged until `mem_req_ready` is seen. At most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbase | input | PA_W | Byte address of the descriptor table |
| cfg_tlen | input | SEG_W+1 | Number of segments in the table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_ofs | input | OFS_W | Offset within the segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | PA_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 56 | Populated low 56 bits of the 8-byte descriptor |
| done | output | 1 | One-cycle result strobe |
| fault | output | 3 | 0 none, 1 table size, 2 invalid, 3 limit, 4 permission |
| phys_addr | output | PA_W | Translated address, 0 on fault |

## Verification
The assertions assume that memory never returns data unless a read has been handed over and is still open. They also assume that `cfg_tbase` and `cfg_tlen` hold steady while a request is in flight. The bench memory model answers each accepted read exactly once, a fixed number of cycles later. The configuration is changed only between requests, after the done pulse. Descriptors are written so that base plus offset never wraps, and every segment number inside the table maps to an entry the model holds.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int DESC_BYTES = 8;
   localparam int DESC_SH    = 3;
   localparam int DBITS      = 56;
   localparam int LIM_W      = 20;
   localparam int BASE_W     = 32;

   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_LEN     = 3'd1,
      FLT_INVALID = 3'd2,
      FLT_LIMIT   = 3'd3,
      FLT_PERM    = 3'd4
   } flt_e;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_BAD = 2'd3
   } acc_e;

   typedef struct packed {
      logic              ex_ok;
      logic              wr_ok;
      logic              rd_ok;
      logic              live;
      logic [LIM_W-1:0]  span;
      logic [BASE_W-1:0] origin;
   } desc_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } st_e;

endpackage

// File: rtl/seg_desc_addr.sv
module seg_desc_addr
   import seg_xlate_pkg::*;
#(
   parameter int PA_W  = 32,
   parameter int SEG_W = 8
) (
   input  logic [PA_W-1:0]  tbase,
   input  logic [SEG_W-1:0] seg,
   output logic [PA_W-1:0]  addr
);

   localparam int SCALED_W = SEG_W + DESC_SH;

   logic [SCALED_W-1:0] scaled;
   logic [PA_W-1:0]     step;

   assign scaled = {seg, {DESC_SH{1'b0}}};

   generate
      if (PA_W > SCALED_W) begin : g_ext
         assign step = {{(PA_W-SCALED_W){1'b0}}, scaled};
      end else begin : g_trunc
         assign step = scaled[PA_W-1:0];
      end
   endgenerate

   assign addr = tbase + step;

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
   import seg_xlate_pkg::*;
#(
   parameter int PA_W  = 32,
   parameter int OFS_W = 20
) (
   input  logic [DBITS-1:0] desc_raw,
   input  logic [OFS_W-1:0] ofs,
   input  logic [1:0]       acc,
   output logic [2:0]       flt,
   output logic [PA_W-1:0]  phys
);

   desc_t            d;
   logic [LIM_W-1:0] ofs_ext;
   logic [PA_W-1:0]  base_ext;
   logic [PA_W-1:0]  ofs_pa;
   logic             perm_ok;

   assign d = desc_t'(desc_raw);

   generate
      if (OFS_W < LIM_W) begin : g_ofs_pad
         assign ofs_ext = {{(LIM_W-OFS_W){1'b0}}, ofs};
      end else begin : g_ofs_full
         assign ofs_ext = ofs;
      end
      if (PA_W > BASE_W) begin : g_base_pad
         assign base_ext = {{(PA_W-BASE_W){1'b0}}, d.origin};
      end else begin : g_base_full
         assign base_ext = d.origin;
      end
   endgenerate

   assign ofs_pa = {{(PA_W-OFS_W){1'b0}}, ofs};

   always_comb begin
      unique case (acc_e'(acc))
         ACC_RD:  perm_ok = d.rd_ok;
         ACC_WR:  perm_ok = d.wr_ok;
         ACC_EX:  perm_ok = d.ex_ok;
         default: perm_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (!d.live)                flt = FLT_INVALID;
      else if (ofs_ext >= d.span) flt = FLT_LIMIT;
      else if (!perm_ok)          flt = FLT_PERM;
      else                        flt = FLT_NONE;
   end

   assign phys = (flt == FLT_NONE) ? (base_ext + ofs_pa) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int PA_W  = 32,
   parameter int SEG_W = 8,
   parameter int OFS_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PA_W-1:0]    cfg_tbase,
   input  logic [SEG_W:0]     cfg_tlen,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SEG_W-1:0]   req_seg,
   input  logic [OFS_W-1:0]   req_ofs,
   input  logic [1:0]         req_acc,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [55:0]        mem_rsp_data,
   output logic               done,
   output logic [2:0]         fault,
   output logic [PA_W-1:0]    phys_addr
);

   generate
      if (PA_W < BASE_W) begin : g_bad_pa
         $error("PA_W must hold the 32-bit segment base");
      end
      if (OFS_W > LIM_W || OFS_W < 1) begin : g_bad_ofs
         $error("OFS_W must be between 1 and the limit field width");
      end
      if (SEG_W < 1 || SEG_W > 24) begin : g_bad_seg
         $error("SEG_W out of supported range");
      end
      if (PA_W < OFS_W) begin : g_bad_mix
         $error("PA_W must not be narrower than OFS_W");
      end
   endgenerate

   st_e              state;
   logic [OFS_W-1:0] ofs_q;
   logic [1:0]       acc_q;
   logic [PA_W-1:0]  addr_q;
   logic             done_q;
   logic [2:0]       fault_q;
   logic [PA_W-1:0]  phys_q;

   logic [PA_W-1:0]  daddr;
   logic [2:0]       chk_flt;
   logic [PA_W-1:0]  chk_phys;
   logic             accept;
   logic             seg_over;

   seg_desc_addr #(.PA_W(PA_W), .SEG_W(SEG_W)) u_addr (
      .tbase (cfg_tbase),
      .seg   (req_seg),
      .addr  (daddr)
   );

   seg_desc_check #(.PA_W(PA_W), .OFS_W(OFS_W)) u_check (
      .desc_raw (mem_rsp_data),
      .ofs      (ofs_q),
      .acc      (acc_q),
      .flt      (chk_flt),
      .phys     (chk_phys)
   );

   assign req_ready = (state == ST_IDLE) && !done_q;
   assign accept    = req_valid && req_ready;
   assign seg_over  = ({1'b0, req_seg} >= cfg_tlen);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ofs_q   <= '0;
         acc_q   <= '0;
         addr_q  <= '0;
         done_q  <= 1'b0;
         fault_q <= FLT_NONE;
         phys_q  <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= FLT_NONE;
         phys_q  <= '0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (seg_over) begin
                     done_q  <= 1'b1;
                     fault_q <= FLT_LEN;
                  end else begin
                     addr_q <= daddr;
                     ofs_q  <= req_ofs;
                     acc_q  <= req_acc;
                     state  <= ST_REQ;
                  end
               end
            end
            ST_REQ: begin
               if (mem_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  done_q  <= 1'b1;
                  fault_q <= chk_flt;
                  phys_q  <= chk_phys;
                  state   <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state == ST_REQ);
   assign mem_req_addr  = addr_q;
   assign done          = done_q;
   assign fault         = fault_q;
   assign phys_addr     = phys_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int PA_W  = 32,
   parameter int SEG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEG_W:0]   cfg_tlen,
   input logic             req_valid,
   input logic             req_ready,
   input logic [SEG_W-1:0] req_seg,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             done,
   input logic [2:0]       fault,
   input logic [PA_W-1:0]  phys_addr
);

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   quiet_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done |-> fault == 3'd0) and (fault != 3'd0 |-> phys_addr == '0));

   // R3
   len_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && ({1'b0, req_seg} >= cfg_tlen))
      |=> (done && fault == 3'd1 && !mem_req_valid));

   // R11
   hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R2
   busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W), .SEG_W(SEG_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_tlen      (cfg_tlen),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_seg       (req_seg),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .done          (done),
   .fault         (fault),
   .phys_addr     (phys_addr)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_tbase = 32'h1000_0000;
   logic [8:0]  cfg_tlen = 9'd6;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_seg = '0;
   logic [19:0] req_ofs = '0;
   logic [1:0]  req_acc = '0;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [55:0] mem_rsp_data;
   logic        done;
   logic [2:0]  fault;
   logic [31:0] phys_addr;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #2.5 clk = ~clk;

   seg_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_tbase(cfg_tbase), .cfg_tlen(cfg_tlen),
      .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
      .req_ofs(req_ofs), .req_acc(req_acc), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .fault(fault), .phys_addr(phys_addr)
   );

   // memory model: one stall cycle before taking a read, answer after a delay
   logic [55:0] table_m [16];
   logic [31:0] seen_addr;
   int          rd_count;
   logic        pending;
   int          lat;
   logic [3:0]  pend_idx;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_req_ready <= 1'b0;
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
         pending       <= 1'b0;
         rd_count      <= 0;
         seen_addr     <= '0;
         lat           <= 0;
         pend_idx      <= '0;
      end else begin
         mem_rsp_valid <= 1'b0;
         mem_req_ready <= 1'b0;
         if (mem_req_valid && mem_req_ready) begin
            seen_addr <= mem_req_addr;
            pend_idx  <= 4'((mem_req_addr - cfg_tbase) >> 3);
            rd_count  <= rd_count + 1;
            pending   <= 1'b1;
            lat       <= 2;
         end else if (mem_req_valid && !pending) begin
            mem_req_ready <= 1'b1;
         end
         if (pending) begin
            if (lat == 0) begin
               mem_rsp_valid <= 1'b1;
               mem_rsp_data  <= table_m[pend_idx];
               pending       <= 1'b0;
            end else begin
               lat <= lat - 1;
            end
         end
      end
   end

   function automatic logic [55:0] mk(input logic [31:0] b, input logic [19:0] l,
                                      input logic v, input logic r,
                                      input logic w, input logic x);
      return {x, w, r, v, l, b};
   endfunction

   task automatic chk(input logic ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic xlate(input logic [7:0] s, input logic [19:0] o,
                        input logic [1:0] a, input logic [2:0] ef,
                        input logic [31:0] ep, input string tag);
      int n;
      int rc0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      rc0 = rd_count;
      req_seg = s; req_ofs = o; req_acc = a; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (ef != 3'd1) chk(!req_ready, {tag, " R2 busy"}, 32'(req_ready), 32'd0);
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk(done, {tag, " R10 done"}, 32'(done), 32'd1);
      chk(fault == ef, {tag, " fault"}, 32'(fault), 32'(ef));
      chk(phys_addr == ep, {tag, " phys"}, phys_addr, ep);
      if (ef == 3'd1)
         chk(rd_count == rc0, {tag, " R3 no read"}, 32'(rd_count), 32'(rc0));
      else
         chk(seen_addr == cfg_tbase + {21'd0, s, 3'd0}, {tag, " R4 addr"},
             seen_addr, cfg_tbase + {21'd0, s, 3'd0});
      @(negedge clk);
      chk(!done && fault == 3'd0, {tag, " R10 pulse"}, {28'd0, done, fault}, 32'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready && !done && fault == 3'd0 && !mem_req_valid, "R1 reset",
          {27'd0, req_ready, done, fault}, 32'h10);
   endtask

   task automatic t_success();
      xlate(8'd0, 20'h00123, 2'd0, 3'd0, 32'h0004_0123, "R8 read");
      xlate(8'd0, 20'h00000, 2'd1, 3'd0, 32'h0004_0000, "R8 write");
      xlate(8'd3, 20'h007FF, 2'd2, 3'd0, 32'hFFFF_F7FF, "R8 high base");
   endtask

   task automatic t_limit();
      xlate(8'd0, 20'h00FFF, 2'd0, 3'd0, 32'h0004_0FFF, "R6 last ok");
      xlate(8'd0, 20'h01000, 2'd0, 3'd3, 32'h0, "R6 at limit");
      xlate(8'd2, 20'hFFFFF, 2'd0, 3'd3, 32'h0, "R6 far");
   endtask

   task automatic t_invalid();
      xlate(8'd1, 20'h00000, 2'd0, 3'd2, 32'h0, "R5 invalid");
   endtask

   task automatic t_perm();
      xlate(8'd0, 20'h00010, 2'd2, 3'd4, 32'h0, "R7 no exec");
      xlate(8'd2, 20'h00010, 2'd1, 3'd4, 32'h0, "R7 no write");
      xlate(8'd2, 20'h0003F, 2'd2, 3'd0, 32'h0010_003F, "R7 exec ok");
      xlate(8'd3, 20'h00000, 2'd3, 3'd4, 32'h0, "R7 reserved type");
   endtask

   task automatic t_order();
      xlate(8'd1, 20'h00300, 2'd1, 3'd2, 32'h0, "R9 invalid over limit");
      xlate(8'd2, 20'h00040, 2'd1, 3'd3, 32'h0, "R9 limit over perm");
      xlate(8'd5, 20'h00000, 2'd3, 3'd2, 32'h0, "R9 last legal invalid");
   endtask

   task automatic t_length();
      xlate(8'd6, 20'h00000, 2'd0, 3'd1, 32'h0, "R3 at length");
      xlate(8'd255, 20'h00000, 2'd0, 3'd1, 32'h0, "R3 top seg");
      cfg_tlen = 9'd0;
      xlate(8'd0, 20'h00000, 2'd0, 3'd1, 32'h0, "R3 empty table");
      cfg_tlen = 9'd6;
   endtask

   task automatic t_rebase();
      cfg_tbase = 32'h2000_0040;
      xlate(8'd2, 20'h00001, 2'd0, 3'd0, 32'h0010_0001, "R4 new base");
      cfg_tbase = 32'h1000_0000;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) table_m[i] = '0;
      table_m[0] = mk(32'h0004_0000, 20'h01000, 1'b1, 1'b1, 1'b1, 1'b0);
      table_m[1] = mk(32'h0008_0000, 20'h00200, 1'b0, 1'b1, 1'b1, 1'b1);
      table_m[2] = mk(32'h0010_0000, 20'h00040, 1'b1, 1'b1, 1'b0, 1'b1);
      table_m[3] = mk(32'hFFFF_F000, 20'h00800, 1'b1, 1'b1, 1'b1, 1'b1);
      table_m[5] = mk(32'h0020_0000, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_success();
      t_limit();
      t_invalid();
      t_perm();
      t_order();
      t_length();
      t_rebase();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

endmodule